// File: doc/BRIEF.md
# Integer Status Flag Updater

This block keeps the fixed-point exception bits and the lowest condition field, and updates them after an integer ALU operation. Each cycle it sees the operands that went into the operation and the result that came out. It compares them to produce a carry on the full width and a carry on the low half. It also produces a signed overflow, a sticky summary overflow, and a signed classification of the result. Three separate enables control the carry update, the overflow update and the condition-field update. A bit whose update is disabled keeps its value.

The operand set is built from the first source, which can be bitwise inverted, an optional second source and an optional immediate. The immediate is treated as one more operand. All flag state sits in registers, and every enabled update takes effect on the same clock edge. The ALU and the other condition fields belong to neighbouring logic.

Top module: `fx_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `ca`, `ca32`, `ov`, `so` and `cr0` to zero.
- R2: When `inv_a` is 1, the bitwise complement of `src_a` replaces `src_a` in every flag evaluation.
- R3: When `imm_vld` is 1, `imm` joins the operand set as one more operand. When it is 0, `imm` has no effect.
- R4: With `carry_en` at 1, `ca` is loaded with 1 if any operand in the set is unsigned-greater than `result`, and with 0 otherwise.
- R5: With `carry_en` at 1, `ca32` is loaded with 1 if the low W/2 bits of any operand are unsigned-greater than the low W/2 bits of `result`, and with 0 otherwise.
- R6: With `ovf_en` at 1 and at least two operands present (`src_b_vld` or `imm_vld` set), `ov` is loaded with 1 exactly when the first two operands share a sign bit and the sign bit of `result` differs from it. The second operand is `src_b` if it is valid, and `imm` otherwise. With only one operand, `ov` is unchanged.
- R7: `so` becomes the OR of its old value and any newly loaded `ov`. Once set, it stays set until reset.
- R8: With `rec_en` at 1, `cr0` is loaded with {LT, GT, EQ, SO} (bit 3 down to bit 0), where LT, GT and EQ compare `result` as a signed value against zero.
- R9: The SO bit written into `cr0[0]` is the value `so` takes on that same edge, after the overflow update.
- R10: An update whose enable is 0 leaves its bits unchanged: `carry_en` guards `ca` and `ca32`, `ovf_en` guards `ov` and `so`, and `rec_en` guards `cr0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_a | input | W | First source operand |
| src_b | input | W | Second source operand |
| src_b_vld | input | 1 | Second source is present |
| imm | input | W | Immediate operand |
| imm_vld | input | 1 | Immediate is present |
| inv_a | input | 1 | Complement the first operand before evaluation |
| result | input | W | ALU result |
| carry_en | input | 1 | Update the carry bits |
| ovf_en | input | 1 | Update the overflow bits |
| rec_en | input | 1 | Update the condition field |
| ca | output | 1 | Carry |
| ca32 | output | 1 | Low-half carry |
| ov | output | 1 | Overflow |
| so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench builds the block with W = 16, so the low half is 8 bits wide. At that width, sign-boundary values such as 0x7FFF + 1 and wrap-around sums are easy to write by hand. Operand pairs are also easy to pick so that the full-width carry and the half-width carry disagree in both directions. Reaching these cases also exercises the R9 ordering, where an overflow and a record update land on the same edge.

// File: rtl/fx_flag_unit.sv
module fx_flag_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         src_b_vld,
  input  logic [W-1:0] imm,
  input  logic         imm_vld,
  input  logic         inv_a,
  input  logic [W-1:0] result,
  input  logic         carry_en,
  input  logic         ovf_en,
  input  logic         rec_en,
  output logic         ca,
  output logic         ca32,
  output logic         ov,
  output logic         so,
  output logic [3:0]   cr0
);
  localparam int H = W / 2;

  logic [W-1:0] opa, opb;
  logic         two_ops, ov_upd, ov_new, so_new;
  logic         cy_full, cy_half;
  logic         r_lt, r_eq, r_gt;

  assign opa     = inv_a ? ~src_a : src_a;
  assign opb     = src_b_vld ? src_b : imm;
  assign two_ops = src_b_vld | imm_vld;

  assign cy_full = (opa > result)
                 | (src_b_vld & (src_b > result))
                 | (imm_vld & (imm > result));
  assign cy_half = (opa[H-1:0] > result[H-1:0])
                 | (src_b_vld & (src_b[H-1:0] > result[H-1:0]))
                 | (imm_vld & (imm[H-1:0] > result[H-1:0]));

  assign ov_upd = ovf_en & two_ops;
  assign ov_new = (opa[W-1] == opb[W-1]) & (result[W-1] != opa[W-1]);
  assign so_new = so | (ov_upd & ov_new);

  assign r_lt = result[W-1];
  assign r_eq = (result == '0);
  assign r_gt = ~r_lt & ~r_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      ca   <= 1'b0;
      ca32 <= 1'b0;
      ov   <= 1'b0;
      so   <= 1'b0;
      cr0  <= 4'b0;
    end else begin
      if (carry_en) begin
        ca   <= cy_full;
        ca32 <= cy_half;
      end
      if (ov_upd) ov <= ov_new;
      so <= so_new;
      if (rec_en) cr0 <= {r_lt, r_gt, r_eq, so_new};
    end
  end
endmodule

// File: rtl/fx_flag_unit_chk.sv
module fx_flag_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         src_b_vld,
  input logic [W-1:0] imm,
  input logic         imm_vld,
  input logic         inv_a,
  input logic [W-1:0] result,
  input logic         carry_en,
  input logic         ovf_en,
  input logic         rec_en,
  input logic         ca,
  input logic         ca32,
  input logic         ov,
  input logic         so,
  input logic [3:0]   cr0
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> ({ca, ca32, ov, so, cr0} == 8'h00));

  assert_so_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    so |=> so);

  assert_carry_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !carry_en |=> $stable({ca, ca32}));

  assert_rec_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rec_en |=> $stable(cr0));

  assert_single_op_ov_R6: assert property (@(posedge clk) disable iff (rst)
    (!src_b_vld && !imm_vld) |=> $stable(ov));

  assert_cr0_so_R9: assert property (@(posedge clk) disable iff (rst)
    rec_en |=> (cr0[0] == so));

  assert_cr0_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rec_en && result == '0) |=> (cr0[3:1] == 3'b001));

  logic unused_ok;
  assign unused_ok = ^{src_a, src_b, imm, inv_a, ovf_en};
endmodule

bind fx_flag_unit fx_flag_unit_chk #(.W(W)) u_chk (.*);

// File: tb/test_fx_flag_unit.sv
module test_fx_flag_unit;
  localparam int W = 16;
  localparam int H = W / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] src_a = '0, src_b = '0, imm = '0, result = '0;
  logic src_b_vld = 1'b0, imm_vld = 1'b0, inv_a = 1'b0;
  logic carry_en = 1'b0, ovf_en = 1'b0, rec_en = 1'b0;
  logic ca, ca32, ov, so;
  logic [3:0] cr0;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic m_ca = 0, m_ca32 = 0, m_ov = 0, m_so = 0;
  logic [3:0] m_cr0 = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fx_flag_unit #(.W(W)) i_fx_flag_unit (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b), .src_b_vld(src_b_vld),
    .imm(imm), .imm_vld(imm_vld), .inv_a(inv_a), .result(result),
    .carry_en(carry_en), .ovf_en(ovf_en), .rec_en(rec_en),
    .ca(ca), .ca32(ca32), .ov(ov), .so(so), .cr0(cr0));

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({ca, ca32, ov, so, cr0} !== e) begin
        errors++;
        $display("FAIL %s: actual {ca,ca32,ov,so,cr0}=%b expected %b", t,
                 {ca, ca32, ov, so, cr0}, e);
      end
    end
  end

  task automatic do_reset(input string t);
    @(negedge clk);
    rst = 1'b1; carry_en = 0; ovf_en = 0; rec_en = 0;
    @(posedge clk); #1;
    m_ca = 0; m_ca32 = 0; m_ov = 0; m_so = 0; m_cr0 = 0;
    exp_q.push_back(8'h00); tag_q.push_back(t);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic bv,
                       input logic [W-1:0] im, input logic iv, input logic inv,
                       input logic [W-1:0] res, input logic ce, input logic oe,
                       input logic re, input string t);
    logic [W-1:0] ops[3];
    logic vld[3];
    logic cf, ch, ovn;
    logic [W-1:0] second;
    @(negedge clk);
    src_a = a; src_b = b; src_b_vld = bv; imm = im; imm_vld = iv; inv_a = inv;
    result = res; carry_en = ce; ovf_en = oe; rec_en = re;
    ops[0] = inv ? ~a : a; vld[0] = 1;
    ops[1] = b; vld[1] = bv;
    ops[2] = im; vld[2] = iv;
    cf = 0; ch = 0;
    for (int k = 0; k < 3; k++) begin
      if (vld[k] && ops[k] > res) cf = 1;
      if (vld[k] && ops[k][H-1:0] > res[H-1:0]) ch = 1;
    end
    second = bv ? b : im;
    ovn = (ops[0][W-1] == second[W-1]) && (res[W-1] != ops[0][W-1]);
    @(posedge clk); #1;
    if (ce) begin m_ca = cf; m_ca32 = ch; end
    if (oe && (bv || iv)) begin m_ov = ovn; m_so = m_so | ovn; end
    if (re) m_cr0 = {$signed(res) < 0, $signed(res) > 0, res == 0, m_so};
    exp_q.push_back({m_ca, m_ca32, m_ov, m_so, m_cr0});
    tag_q.push_back(t);
  endtask

  initial begin
    do_reset("R1 reset state");
    drive(16'hFFFF, 16'h0001, 1, 0, 0, 0, 16'h0000, 1, 0, 0, "R4 R5 wrap carry");
    drive(16'h0001, 16'h0002, 1, 0, 0, 0, 16'h0003, 1, 0, 0, "R4 R5 no carry");
    drive(16'h00F0, 16'h0020, 1, 0, 0, 0, 16'h0110, 1, 0, 0, "R5 half carry only");
    drive(16'h1000, 16'h0001, 1, 0, 0, 0, 16'h0F80, 1, 0, 0, "R4 full carry only");
    drive(16'hFFFE, 16'h0002, 1, 0, 0, 1, 16'h0003, 1, 0, 0, "R2 inverted operand");
    drive(16'h0001, 0, 0, 16'h8000, 1, 0, 16'h0005, 1, 0, 0, "R3 immediate operand");
    drive(16'h0001, 0, 0, 16'h8000, 0, 0, 16'h0005, 1, 0, 0, "R3 immediate ignored");
    drive(16'h7FFF, 16'h0001, 1, 0, 0, 0, 16'h8000, 0, 1, 0, "R6 overflow set");
    drive(16'h0001, 16'h0001, 1, 0, 0, 0, 16'h0002, 0, 1, 0, "R7 sticky so");
    drive(16'h8000, 0, 0, 16'h8000, 1, 0, 16'h0000, 0, 1, 0, "R6 imm second operand");
    drive(16'h7FFF, 0, 0, 0, 0, 0, 16'h8000, 0, 1, 0, "R6 single operand hold");
    drive(0, 0, 0, 0, 0, 0, 16'h8000, 0, 0, 1, "R8 negative");
    drive(0, 0, 0, 0, 0, 0, 16'h0000, 0, 0, 1, "R8 zero");
    drive(0, 0, 0, 0, 0, 0, 16'h0042, 0, 0, 1, "R8 positive");
    drive(16'hFFFF, 16'h7FFF, 1, 0, 0, 0, 16'h0000, 0, 0, 0, "R10 all disabled");
    do_reset("R1 reset clears sticky");
    drive(16'h4000, 16'h4000, 1, 0, 0, 0, 16'h8000, 0, 1, 1, "R9 so into cr0");
    drive(16'h0003, 16'h0004, 1, 0, 0, 0, 16'h0001, 1, 1, 1, "R4 R6 R8 combined");
    @(negedge clk); carry_en = 0; ovf_en = 0; rec_en = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule